// File: doc/BRIEF.md
# GPIO Port with Interrupt Capture

This block is a 32-pin general-purpose I/O port controlled through a small memory-mapped register set with 32-bit data. Software drives pin values and pin directions either by writing a whole register or by using separate set and clear addresses. The set and clear addresses change only the bits written as one, so two agents can update different pins without a read-modify-write.

Pin inputs are brought into the clock domain through a two-flop synchronizer. Each pin has its own event detector. The detector can sense edges or levels, and it can use positive or negative polarity. A both-edges option overrides polarity in edge mode. Detected events are held in a capture register, and software clears that register by writing ones. A per-pin enable mask gates the captured events onto one summary interrupt line. The pins appear as separate input, output-value and output-enable vectors. Pad multiplexing is handled elsewhere.

The register port is a plain strobe interface and has no back-pressure. A write takes effect at the clock edge where `reg_we` is high. A read returns its data on `reg_rdata` at the clock edge after the edge where `reg_re` is high, and that value is held until the next read.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, every register reads 0, `pin_out` and `pin_oe` are 0, and `irq` is 0. This means all pins are inputs, every pin senses rising edges, and every interrupt is disabled.
- R2: Offset 0x00 holds the output value and drives `pin_out`. Offset 0x08 holds the direction and drives `pin_oe`, where a 1 makes the pin an output. Both offsets can be written and read back.
- R3: Writing to 0x40 sets the output bits written as 1, and writing to 0x44 clears them. Writing to 0x48 sets the direction bits written as 1, and writing to 0x4C clears them. Bits written as 0 are left unchanged. Reading any of these four addresses returns the register they target.
- R4: Offset 0x04 returns the pin inputs after the two-flop synchronizer. It is read-only, and writes to it have no effect.
- R5: In edge mode (bit 0 at the sense-mode register 0x2C), a 0 at 0x18 selects rising-edge detection and a 1 selects falling-edge detection. Edges of the opposite direction are not captured.
- R6: A 1 at 0x1C makes an edge-mode pin capture both rising and falling edges, whatever its bit at 0x18 holds.
- R7: In level mode (bit 1 at 0x2C), the capture bit is set on every cycle the active level is present. A 0 at 0x18 makes high the active level, and a 1 makes low the active level. Clearing the capture bit while the level is still active leaves it set.
- R8: Offset 0x20 reads the captured events. Writing a 1 to a bit clears that bit, and writing a 0 has no effect. If an edge arrives in the same cycle as its clear, the bit stays set.
- R9: Writing a 1 to 0x30 enables that pin's interrupt, and writing a 1 to 0x34 disables it. Bits written as 0 are ignored. Reading either address returns the enable mask.
- R10: `irq` is high exactly when some pin has both its capture bit and its enable bit set. Events are captured whether or not the pin is enabled.
- R11: Read data appears on `reg_rdata` one cycle after `reg_re`. Addresses outside the map read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one cycle after `reg_re` |
| pin_in | input | 32 | Raw pin inputs (asynchronous) |
| pin_out | output | 32 | Pin output values |
| pin_oe | output | 32 | Pin output enables, 1 = drive |
| irq | output | 1 | Summary interrupt for the port |

## Verification
The bench makes a capture clear and a fresh edge land on the same clock edge. A design that gives the clear priority would lose that event and read back 0 where 8 is expected. It clears a level-mode bit while the level is still held, which catches a design that keeps level events sticky instead of re-arming them every cycle. It also drives edges in the direction that should be ignored, and sets the both-edges bit together with negative polarity, to expose detectors that mix up polarity and the override. Finally, it writes zero masks to every set and clear alias and writes to the read-only input offset, so that a design which treats the aliases as plain registers shows up as a changed readback.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFF_OUT    = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_IN     = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_DIR    = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_POL    = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_BOTH   = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_CAP    = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_MODE   = 8'h2C;
  localparam logic [ADDR_W-1:0] OFF_ENSET  = 8'h30;
  localparam logic [ADDR_W-1:0] OFF_ENCLR  = 8'h34;
  localparam logic [ADDR_W-1:0] OFF_OUTSET = 8'h40;
  localparam logic [ADDR_W-1:0] OFF_OUTCLR = 8'h44;
  localparam logic [ADDR_W-1:0] OFF_DIRSET = 8'h48;
  localparam logic [ADDR_W-1:0] OFF_DIRCLR = 8'h4C;

  // per-pin sense selection
  typedef struct packed {
    logic level;  // 1: level sensing, 0: edge sensing
    logic neg;    // 1: falling edge / low level
    logic both;   // 1: both edges (edge mode only)
  } sense_t;

  function automatic logic addr_mapped(input logic [ADDR_W-1:0] a);
    case (a)
      OFF_OUT, OFF_IN, OFF_DIR, OFF_POL, OFF_BOTH, OFF_CAP, OFF_MODE,
      OFF_ENSET, OFF_ENCLR, OFF_OUTSET, OFF_OUTCLR, OFF_DIRSET,
      OFF_DIRCLR: addr_mapped = 1'b1;
      default:    addr_mapped = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) st_q[k] <= '0;
    end else begin
      st_q[0] <= din;
      for (int k = 1; k < STAGES; k++) st_q[k] <= st_q[k-1];
    end
  end

  assign dout = st_q[STAGES-1];
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
  import gpio_port_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sync_vec,
  input  logic [W-1:0] lvl_sel,
  input  logic [W-1:0] neg_sel,
  input  logic [W-1:0] both_sel,
  output logic [W-1:0] evt_vec
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sync_vec;
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    sense_t sense;
    logic   rise, fall, lvl_hit, edge_hit;

    assign sense    = {lvl_sel[i], neg_sel[i], both_sel[i]};
    assign rise     = sync_vec[i] & ~prev_q[i];
    assign fall     = ~sync_vec[i] & prev_q[i];
    assign lvl_hit  = sense.neg ? ~sync_vec[i] : sync_vec[i];
    assign edge_hit = sense.both ? (rise | fall) : (sense.neg ? fall : rise);
    assign evt_vec[i] = sense.level ? lvl_hit : edge_hit;
  end
endmodule

// File: rtl/gpio_setclr_reg.sv
module gpio_setclr_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] set_mask,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= wr_data;
    else            q <= (q | set_mask) & ~clr_mask;
  end
endmodule

// File: rtl/gpio_irq_capture.sv
module gpio_irq_capture #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_vec,
  input  logic [W-1:0] clr_mask,
  input  logic [W-1:0] en_set,
  input  logic [W-1:0] en_clr,
  output logic [W-1:0] cap_vec,
  output logic [W-1:0] en_vec,
  output logic         irq
);
  // new events win over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_vec <= '0;
    else        cap_vec <= (cap_vec & ~clr_mask) | evt_vec;
  end

  gpio_setclr_reg #(.W(W)) u_en (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (1'b0),
    .wr_data  ('0),
    .set_mask (en_set),
    .clr_mask (en_clr),
    .q        (en_vec)
  );

  assign irq = |(cap_vec & en_vec);
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_port_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [NPINS-1:0]  reg_wdata,
  output logic [NPINS-1:0]  reg_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);
  localparam logic [NPINS-1:0] ZERO = '0;

  logic [NPINS-1:0] sync_vec, evt_vec, cap_vec, en_vec;
  logic [NPINS-1:0] out_q, dir_q, pol_q, both_q, mode_q;
  logic [NPINS-1:0] rd_mux;

  // write decode
  logic wr_out, wr_dir, wr_pol, wr_both, wr_mode;
  logic wr_cap, wr_enset, wr_enclr, wr_outset, wr_outclr, wr_dirset, wr_dirclr;

  assign wr_out    = reg_we && (reg_addr == OFF_OUT);
  assign wr_dir    = reg_we && (reg_addr == OFF_DIR);
  assign wr_pol    = reg_we && (reg_addr == OFF_POL);
  assign wr_both   = reg_we && (reg_addr == OFF_BOTH);
  assign wr_mode   = reg_we && (reg_addr == OFF_MODE);
  assign wr_cap    = reg_we && (reg_addr == OFF_CAP);
  assign wr_enset  = reg_we && (reg_addr == OFF_ENSET);
  assign wr_enclr  = reg_we && (reg_addr == OFF_ENCLR);
  assign wr_outset = reg_we && (reg_addr == OFF_OUTSET);
  assign wr_outclr = reg_we && (reg_addr == OFF_OUTCLR);
  assign wr_dirset = reg_we && (reg_addr == OFF_DIRSET);
  assign wr_dirclr = reg_we && (reg_addr == OFF_DIRCLR);

  gpio_in_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (pin_in),
    .dout  (sync_vec)
  );

  gpio_setclr_reg #(.W(NPINS)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_out),
    .wr_data  (reg_wdata),
    .set_mask (wr_outset ? reg_wdata : ZERO),
    .clr_mask (wr_outclr ? reg_wdata : ZERO),
    .q        (out_q)
  );

  gpio_setclr_reg #(.W(NPINS)) u_dir (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_dir),
    .wr_data  (reg_wdata),
    .set_mask (wr_dirset ? reg_wdata : ZERO),
    .clr_mask (wr_dirclr ? reg_wdata : ZERO),
    .q        (dir_q)
  );

  // sense configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q  <= '0;
      both_q <= '0;
      mode_q <= '0;
    end else begin
      if (wr_pol)  pol_q  <= reg_wdata;
      if (wr_both) both_q <= reg_wdata;
      if (wr_mode) mode_q <= reg_wdata;
    end
  end

  gpio_evt_detect #(.W(NPINS)) u_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_vec (sync_vec),
    .lvl_sel  (mode_q),
    .neg_sel  (pol_q),
    .both_sel (both_q),
    .evt_vec  (evt_vec)
  );

  gpio_irq_capture #(.W(NPINS)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_vec  (evt_vec),
    .clr_mask (wr_cap ? reg_wdata : ZERO),
    .en_set   (wr_enset ? reg_wdata : ZERO),
    .en_clr   (wr_enclr ? reg_wdata : ZERO),
    .cap_vec  (cap_vec),
    .en_vec   (en_vec),
    .irq      (irq)
  );

  // read path
  always_comb begin
    case (reg_addr)
      OFF_OUT, OFF_OUTSET, OFF_OUTCLR: rd_mux = out_q;
      OFF_DIR, OFF_DIRSET, OFF_DIRCLR: rd_mux = dir_q;
      OFF_IN:                          rd_mux = sync_vec;
      OFF_POL:                         rd_mux = pol_q;
      OFF_BOTH:                        rd_mux = both_q;
      OFF_MODE:                        rd_mux = mode_q;
      OFF_CAP:                         rd_mux = cap_vec;
      OFF_ENSET, OFF_ENCLR:            rd_mux = en_vec;
      default:                         rd_mux = ZERO;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_re) reg_rdata <= rd_mux;
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
  import gpio_port_pkg::*;
#(
  parameter int NPINS = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic              reg_re,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [NPINS-1:0]  reg_wdata,
  input logic [NPINS-1:0]  reg_rdata,
  input logic [NPINS-1:0]  pin_out,
  input logic [NPINS-1:0]  pin_oe,
  input logic              irq,
  input logic [NPINS-1:0]  cap_vec,
  input logic [NPINS-1:0]  en_vec,
  input logic [NPINS-1:0]  evt_vec
);
  logic [NPINS-1:0] clr_m;
  assign clr_m = (reg_we && reg_addr == OFF_CAP) ? reg_wdata : '0;

  p_outset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == OFF_OUTSET) |=> ((pin_out & $past(reg_wdata)) == $past(reg_wdata)));

  p_dirclr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == OFF_DIRCLR) |=> ((pin_oe & $past(reg_wdata)) == '0));

  p_dir_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && (reg_addr == OFF_DIR || reg_addr == OFF_DIRSET || reg_addr == OFF_DIRCLR))
      |=> $stable(pin_oe));

  p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == OFF_CAP) |=> ((cap_vec & $past(reg_wdata) & ~$past(evt_vec)) == '0));

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(cap_vec) & ~$past(clr_m)) & ~cap_vec) == '0));

  p_enset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == OFF_ENSET) |=> ((en_vec & $past(reg_wdata)) == $past(reg_wdata)));

  p_no_irq_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en_vec == '0) |-> !irq);

  p_unmapped_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_re && !addr_mapped(reg_addr)) |=> (reg_rdata == '0));
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPINS(NPINS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_re    (reg_re),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .irq       (irq),
  .cap_vec   (cap_vec),
  .en_vec    (en_vec),
  .evt_vec   (evt_vec)
);

// File: tb/gpio_irq_port_tb.sv
module gpio_irq_port_tb;
  localparam logic [7:0] A_OUT = 8'h00, A_IN = 8'h04, A_DIR = 8'h08,
    A_POL = 8'h18, A_BOTH = 8'h1C, A_CAP = 8'h20, A_MODE = 8'h2C,
    A_ENS = 8'h30, A_ENC = 8'h34, A_OS = 8'h40, A_OC = 8'h44,
    A_DS = 8'h48, A_DC = 8'h4C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic        irq;

  int checks = 0;
  int fails = 0;
  logic rd_pend = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  gpio_irq_port u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  // driver: issue read, push expected value to the scoreboard
  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_re = 1'b1; reg_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic setpin(input int idx, input logic v);
    @(negedge clk);
    pin_in[idx] = v;
    idle(4);
  endtask

  always @(posedge clk) rd_pend <= reg_re;

  // monitor: compare read data one cycle after the strobe
  always @(negedge clk) begin
    if (rd_pend) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R11 unexpected read data actual=%h expected=none", reg_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, reg_rdata, e);
      end
    end
  end

  initial begin
    #(4 * 20000);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk("R1 pin_out", pin_out, 32'h0);
    chk("R1 pin_oe", pin_oe, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    rd(A_OUT, 32'h0, "R1 out");
    rd(A_DIR, 32'h0, "R1 dir");
    rd(A_CAP, 32'h0, "R1 cap");
    rd(A_ENS, 32'h0, "R1 enable");
    rd(A_MODE, 32'h0, "R1 mode");
    rd(A_POL, 32'h0, "R1 polarity");
    rd(A_BOTH, 32'h0, "R1 both");

    // R2 direct registers
    wr(A_OUT, 32'hA5A5_0F0F);
    chk("R2 pin_out", pin_out, 32'hA5A5_0F0F);
    rd(A_OUT, 32'hA5A5_0F0F, "R2 out readback");
    wr(A_DIR, 32'hFFFF_0000);
    chk("R2 pin_oe", pin_oe, 32'hFFFF_0000);
    rd(A_DIR, 32'hFFFF_0000, "R2 dir readback");

    // R3 set/clear aliases
    wr(A_OS, 32'h0000_00F0);
    wr(A_OC, 32'hA000_0001);
    chk("R3 out set/clr", pin_out, 32'h05A5_0FFE);
    rd(A_OS, 32'h05A5_0FFE, "R3 out alias read");
    wr(A_DS, 32'h0000_00FF);
    wr(A_DC, 32'h0F00_0000);
    chk("R3 dir set/clr", pin_oe, 32'hF0FF_00FF);
    wr(A_OS, 32'h0); wr(A_OC, 32'h0); wr(A_DS, 32'h0); wr(A_DC, 32'h0);
    chk("R3 zero mask out", pin_out, 32'h05A5_0FFE);
    chk("R3 zero mask dir", pin_oe, 32'hF0FF_00FF);
    rd(A_DC, 32'hF0FF_00FF, "R3 dir alias read");

    // R4 synchronized input, read-only
    @(negedge clk); pin_in = 32'h1234_5678;
    idle(4);
    rd(A_IN, 32'h1234_5678, "R4 input");
    wr(A_IN, 32'hFFFF_FFFF);
    rd(A_IN, 32'h1234_5678, "R4 input write ignored");

    // R10 capture without enable; R8 W1C
    rd(A_CAP, 32'h1234_5678, "R10 capture while disabled");
    chk("R10 irq disabled", {31'h0, irq}, 32'h0);
    wr(A_CAP, 32'h0000_0078);
    rd(A_CAP, 32'h1234_5600, "R8 partial clear");
    wr(A_CAP, 32'h0);
    rd(A_CAP, 32'h1234_5600, "R8 zero write");
    wr(A_CAP, 32'hFFFF_FFFF);
    @(negedge clk); pin_in = 32'h0;
    idle(4);
    rd(A_CAP, 32'h0, "R5 falling ignored in rising mode");

    // R5 falling edge on pin 1
    wr(A_POL, 32'h0000_0002);
    setpin(1, 1'b1);
    rd(A_CAP, 32'h0, "R5 rising ignored in falling mode");
    setpin(1, 1'b0);
    rd(A_CAP, 32'h0000_0002, "R5 falling captured");
    wr(A_CAP, 32'h0000_0002);

    // R6 both edges on pin 2
    wr(A_BOTH, 32'h0000_0004);
    setpin(2, 1'b1);
    rd(A_CAP, 32'h0000_0004, "R6 rise with both");
    wr(A_CAP, 32'h0000_0004);
    setpin(2, 1'b0);
    rd(A_CAP, 32'h0000_0004, "R6 fall with both");
    wr(A_CAP, 32'h0000_0004);
    wr(A_POL, 32'h0000_0006);
    setpin(2, 1'b1);
    rd(A_CAP, 32'h0000_0004, "R6 rise with both and negative polarity");
    setpin(2, 1'b0);
    wr(A_CAP, 32'hFFFF_FFFF);
    rd(A_CAP, 32'h0, "R8 full clear");
    rd(A_POL, 32'h0000_0006, "R5 polarity readback");
    rd(A_BOTH, 32'h0000_0004, "R6 both readback");

    // R9 enable set/clear
    wr(A_ENS, 32'h0000_0010);
    rd(A_ENS, 32'h0000_0010, "R9 enable via set addr");
    rd(A_ENC, 32'h0000_0010, "R9 enable via clear addr");
    wr(A_ENS, 32'h0000_0100);
    wr(A_ENC, 32'h0000_0010);
    wr(A_ENC, 32'h0);
    wr(A_ENS, 32'h0);
    rd(A_ENS, 32'h0000_0100, "R9 set/clear masks");
    chk("R10 irq idle", {31'h0, irq}, 32'h0);

    // R10 summary interrupt
    setpin(8, 1'b1);
    chk("R10 irq on enabled pin", {31'h0, irq}, 32'h1);
    rd(A_CAP, 32'h0000_0100, "R10 capture pin 8");
    wr(A_CAP, 32'h0000_0100);
    chk("R10 irq drops after clear", {31'h0, irq}, 32'h0);
    setpin(9, 1'b1);
    chk("R10 irq masked pin", {31'h0, irq}, 32'h0);
    rd(A_CAP, 32'h0000_0200, "R10 masked pin captured");
    wr(A_CAP, 32'hFFFF_FFFF);

    // R7 level sensing on pin 15
    wr(A_MODE, 32'h0000_8000);
    rd(A_MODE, 32'h0000_8000, "R7 mode readback");
    setpin(15, 1'b1);
    rd(A_CAP, 32'h0000_8000, "R7 high level");
    wr(A_CAP, 32'h0000_8000);
    rd(A_CAP, 32'h0000_8000, "R7 clear while level active");
    setpin(15, 1'b0);
    wr(A_CAP, 32'hFFFF_FFFF);
    rd(A_CAP, 32'h0, "R7 clear after level gone");
    wr(A_POL, 32'h0000_8006);
    idle(2);
    rd(A_CAP, 32'h0000_8000, "R7 low level");
    setpin(15, 1'b1);
    wr(A_CAP, 32'hFFFF_FFFF);
    rd(A_CAP, 32'h0, "R7 low level released");

    // R8 edge beats clear in the same cycle (pin 3, rising)
    setpin(3, 1'b1);
    rd(A_CAP, 32'h0000_0008, "R8 pin 3 rise");
    setpin(3, 1'b0);
    @(negedge clk); pin_in[3] = 1'b1;
    @(negedge clk);
    wr(A_CAP, 32'h0000_0008);
    rd(A_CAP, 32'h0000_0008, "R8 new edge wins over clear");
    wr(A_CAP, 32'h0000_0008);
    rd(A_CAP, 32'h0, "R8 clear without edge");

    // R11 unmapped addresses
    rd(8'h10, 32'h0, "R11 unmapped 0x10");
    rd(8'h50, 32'h0, "R11 unmapped 0x50");
    idle(3);
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R11 reads outstanding actual=%0d expected=0", exp_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule